// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary Presentation

This block keeps a calendar and a time of day: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second strobe from an external divider drives it forward by one second. Each field is shown as an 8-bit byte, in packed BCD or plain binary. Hours are shown in 24-hour form or in 12-hour form, with the afternoon marked in bit 7. A host-side register file wraps the block and feeds it the mode bits, a hold bit, an oscillator/divider control field and a parallel load of all seven bytes.

The count is kept in binary and is formatted only when the visible bytes are refreshed. After an accepted second, a busy flag goes high. A fixed number of cycles later, the visible bytes take the new time, the busy flag drops and a one-cycle done strobe fires. While the hold bit is high, the internal count may still move but the visible bytes stay frozen. When hold is released, the internal count is reloaded from the visible bytes, so software edits made under hold take effect. The leap-year test forms a full year from a fixed base century and the two-digit year.

Top module: `cal_time_counter`

## Requirements
- R1: With `bin_mode_i`=1 every field byte is plain binary. With `bin_mode_i`=0 it is packed BCD: the tens digit is in bits 7:4 and the units digit in bits 3:0. Loaded bytes are decoded in the same encoding.
- R2: With `h24_mode_i`=1 the hours byte holds 0 to 23. With `h24_mode_i`=0 it holds the hour mod 12, and bit 7 is set when the hour is 12 or more (so noon reads 0 with bit 7 set). When a load is made in 12-hour mode, bit 7 of the loaded hours byte adds 12.
- R3: Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the date.
- R4: Day of week counts 1 to 7. It wraps from 7 to 1 and steps only at midnight.
- R5: Month lengths are 31 days, except 30 for months 4, 6, 9 and 11 and 28 for month 2. February has 29 days when the full year (BASE_CENTURY*100 plus the two-digit year) is divisible by 4 and not by 100, or is divisible by 400.
- R6: Month counts 1 to 12 and wraps from 12 to 1, which steps the year. The year counts 0 to 99 and wraps from 99 to 0.
- R7: A tick is accepted only when `osc_ctl_i` equals 3'b010 and no update is in flight. Any other tick changes nothing.
- R8: With hold low, `busy_o` is high from the edge that accepts a tick. Exactly UPD_DELAY edges later the visible bytes change, `busy_o` falls and `done_o` is high for that one cycle.
- R9: While `hold_i` is high, `busy_o` stays low, `done_o` stays low and the visible bytes are not refreshed. On the edge that sees hold fall, the internal count is reloaded from the visible bytes.
- R10: `load_i` writes all seven visible bytes on the next edge and, with hold low, sets the internal count too. Load wins over a tick in the same cycle and cancels an update in flight.
- R11: After reset the visible bytes read 00:00:00, day of week 1, date 01/01, year 00, with `busy_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| osc_ctl_i | input | 3 | Divider control; 3'b010 lets time run |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = packed BCD |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| hold_i | input | 1 | Freeze visible bytes |
| load_i | input | 1 | Load all seven bytes |
| ld_sec_i | input | 8 | Seconds byte to load |
| ld_min_i | input | 8 | Minutes byte to load |
| ld_hour_i | input | 8 | Hours byte to load |
| ld_wday_i | input | 8 | Day-of-week byte to load |
| ld_mday_i | input | 8 | Day-of-month byte to load |
| ld_mon_i | input | 8 | Month byte to load |
| ld_year_i | input | 8 | Year byte to load |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hours |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| year_o | output | 8 | Visible year |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | Update finished strobe |

## Verification
A load is visible one edge after `load_i` is sampled, so the bench reads the bytes at the falling edge that follows. A tick accepted at edge E0 raises `busy_o` at once. The new bytes and `done_o` appear at edge E0+UPD_DELAY, and the bench samples both at the falling edges just before and just after that edge. In the cases where nothing may happen (wrong divider field, hold high, load over tick), the bench watches `busy_o` and `done_o` on every falling edge for the whole update window and reads the bytes after the window closes.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

    localparam logic [2:0] OSC_RUN = 3'b010;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_bytes_t;

    localparam cal_time_t TIME_RST = '{yr: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                                       hour: 5'd0, min: 6'd0, sec: 6'd0};
    localparam cal_bytes_t BYTES_RST = '{yr: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h01,
                                         hour: 8'h00, min: 8'h00, sec: 8'h00};

    // binary value 0..99 -> byte in the selected encoding
    function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v - tens * 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], units[3:0]};
    endfunction

    // byte in the selected encoding -> binary value
    function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin);
        logic [7:0] sum;
        sum = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
        return bin ? b[6:0] : sum[6:0];
    endfunction

endpackage

// File: rtl/cal_advance.sv
`timescale 1ns/1ps
module cal_advance
    import cal_pkg::*;
#(
    parameter int BASE_CENTURY = 20
) (
    input  cal_time_t cur,
    output cal_time_t nxt
);
    localparam logic CENT_LEAP = ((BASE_CENTURY % 4) == 0);

    logic       leap;
    logic [4:0] dim;

    always_comb begin
        leap = (cur.yr == 7'd0) ? CENT_LEAP : (cur.yr[1:0] == 2'b00);
        case (cur.mon)
            4'd2:                        dim = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:     dim = 5'd30;
            default:                     dim = 5'd31;
        endcase

        nxt = cur;
        if (cur.sec != 6'd59) begin
            nxt.sec = cur.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (cur.min != 6'd59) begin
                nxt.min = cur.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (cur.hour != 5'd23) begin
                    nxt.hour = cur.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.mday < dim) begin
                        nxt.mday = cur.mday + 5'd1;
                    end else begin
                        nxt.mday = 5'd1;
                        if (cur.mon < 4'd12) begin
                            nxt.mon = cur.mon + 4'd1;
                        end else begin
                            nxt.mon = 4'd1;
                            nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cal_format.sv
`timescale 1ns/1ps
module cal_format
    import cal_pkg::*;
(
    input  cal_time_t  t,
    input  logic       bin,
    input  logic       h24,
    output cal_bytes_t b
);
    logic       pm;
    logic [4:0] h12;

    always_comb begin
        pm  = (t.hour >= 5'd12);
        h12 = pm ? t.hour - 5'd12 : t.hour;
        b.sec  = enc_field({1'b0, t.sec}, bin);
        b.min  = enc_field({1'b0, t.min}, bin);
        b.hour = h24 ? enc_field({2'b0, t.hour}, bin)
                     : (enc_field({2'b0, h12}, bin) | {pm, 7'd0});
        b.wday = enc_field({4'd0, t.wday}, bin);
        b.mday = enc_field({2'b0, t.mday}, bin);
        b.mon  = enc_field({3'd0, t.mon}, bin);
        b.yr   = enc_field(t.yr, bin);
    end
endmodule

// File: rtl/cal_decode.sv
`timescale 1ns/1ps
module cal_decode
    import cal_pkg::*;
(
    input  cal_bytes_t b,
    input  logic       bin,
    input  logic       h24,
    output cal_time_t  t
);
    logic [6:0] sec_v, min_v, hr_v, wd_v, md_v, mo_v, yr_v;
    logic [6:0] hr_adj;

    always_comb begin
        sec_v  = dec_field(b.sec, bin);
        min_v  = dec_field(b.min, bin);
        hr_v   = dec_field({1'b0, b.hour[6:0]}, bin);
        wd_v   = dec_field(b.wday, bin);
        md_v   = dec_field(b.mday, bin);
        mo_v   = dec_field(b.mon, bin);
        yr_v   = dec_field(b.yr, bin);
        hr_adj = (!h24 && b.hour[7]) ? hr_v + 7'd12 : hr_v;
        t.sec  = sec_v[5:0];
        t.min  = min_v[5:0];
        t.hour = hr_adj[4:0];
        t.wday = wd_v[2:0];
        t.mday = md_v[4:0];
        t.mon  = mo_v[3:0];
        t.yr   = yr_v;
    end
endmodule

// File: rtl/cal_time_counter.sv
`timescale 1ns/1ps
module cal_time_counter
    import cal_pkg::*;
#(
    parameter int UPD_DELAY    = 4,
    parameter int BASE_CENTURY = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [2:0] osc_ctl_i,
    input  logic       bin_mode_i,
    input  logic       h24_mode_i,
    input  logic       hold_i,
    input  logic       load_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hour_i,
    input  logic [7:0] ld_wday_i,
    input  logic [7:0] ld_mday_i,
    input  logic [7:0] ld_mon_i,
    input  logic [7:0] ld_year_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int PW = $clog2(UPD_DELAY + 1);
    localparam logic [PW-1:0] PEND_START = PW'(UPD_DELAY);
    localparam logic [PW-1:0] PEND_LAST  = PW'(1);

    typedef struct packed {
        cal_time_t     cnt;
        cal_bytes_t    vis;
        logic          busy;
        logic          done;
        logic          hold;
        logic [PW-1:0] pend;
    } state_t;

    state_t     s_d, s_q;
    cal_time_t  cnt_next, load_t, vis_t;
    cal_bytes_t load_b, fmt_b;
    logic       tick_ok;

    assign load_b = '{yr: ld_year_i, mon: ld_mon_i, mday: ld_mday_i, wday: ld_wday_i,
                      hour: ld_hour_i, min: ld_min_i, sec: ld_sec_i};

    cal_advance #(.BASE_CENTURY(BASE_CENTURY)) u_adv (.cur(s_q.cnt), .nxt(cnt_next));
    cal_format  u_fmt (.t(s_q.cnt), .bin(bin_mode_i), .h24(h24_mode_i), .b(fmt_b));
    cal_decode  u_dec_ld  (.b(load_b), .bin(bin_mode_i), .h24(h24_mode_i), .t(load_t));
    cal_decode  u_dec_vis (.b(s_q.vis), .bin(bin_mode_i), .h24(h24_mode_i), .t(vis_t));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.hold = hold_i;
        tick_ok  = tick_i && (osc_ctl_i == OSC_RUN) && (s_q.pend == '0);
        if (load_i) begin
            s_d.vis  = load_b;
            if (!hold_i) s_d.cnt = load_t;
            s_d.pend = '0;
            s_d.busy = 1'b0;
        end else begin
            if (s_q.hold && !hold_i) s_d.cnt = vis_t;
            if (tick_ok) begin
                s_d.cnt  = cnt_next;
                s_d.pend = PEND_START;
                s_d.busy = !hold_i;
            end else if (s_q.pend != '0) begin
                s_d.pend = s_q.pend - PEND_LAST;
                if (s_q.pend == PEND_LAST) begin
                    s_d.busy = 1'b0;
                    if (!hold_i) begin
                        s_d.vis  = fmt_b;
                        s_d.done = 1'b1;
                    end
                end
            end
            if (hold_i) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: TIME_RST, vis: BYTES_RST, busy: 1'b0, done: 1'b0,
                     hold: 1'b0, pend: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sec_o  = s_q.vis.sec;
    assign min_o  = s_q.vis.min;
    assign hour_o = s_q.vis.hour;
    assign wday_o = s_q.vis.wday;
    assign mday_o = s_q.vis.mday;
    assign mon_o  = s_q.vis.mon;
    assign year_o = s_q.vis.yr;
    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
endmodule

// File: rtl/cal_time_counter_chk.sv
`timescale 1ns/1ps
module cal_time_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] osc_ctl_i,
    input logic       hold_i,
    input logic       load_i,
    input logic [7:0] sec_o,
    input logic [7:0] hour_o,
    input logic [7:0] mday_o,
    input logic       busy_o,
    input logic       done_o
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_hold_no_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !busy_o);

    assert_hold_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !done_o);

    assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i) |=> ($stable(sec_o) && $stable(hour_o) && $stable(mday_o)));

    assert_osc_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && osc_ctl_i != 3'b010) |=> !busy_o);
endmodule

bind cal_time_counter cal_time_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .osc_ctl_i(osc_ctl_i), .hold_i(hold_i), .load_i(load_i),
    .sec_o(sec_o), .hour_o(hour_o), .mday_o(mday_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_cal_time_counter.sv
`timescale 1ns/1ps
module sim_cal_time_counter;
    localparam int D  = 4;
    localparam int NV = 11;

    typedef struct packed {
        logic        bin;
        logic        h24;
        logic [55:0] ld;   // {yr,mon,mday,wday,hour,min,sec}
        logic [55:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 56'h24_02_28_07_23_59_59, 56'h24_02_29_01_00_00_00}, // leap Feb
        '{1'b0, 1'b1, 56'h23_02_28_03_23_59_59, 56'h23_03_01_04_00_00_00}, // plain Feb
        '{1'b0, 1'b1, 56'h99_12_31_05_23_59_59, 56'h00_01_01_06_00_00_00}, // year wrap
        '{1'b0, 1'b1, 56'h00_02_28_02_23_59_59, 56'h00_02_29_03_00_00_00}, // 2000 leap
        '{1'b1, 1'b1, 56'h32_04_1E_01_17_3B_3B, 56'h32_05_01_02_00_00_00}, // binary, 30-day
        '{1'b0, 1'b0, 56'h30_06_15_01_11_59_59, 56'h30_06_15_01_80_00_00}, // noon 12h
        '{1'b0, 1'b0, 56'h30_06_15_02_91_59_59, 56'h30_06_16_03_00_00_00}, // midnight 12h
        '{1'b1, 1'b0, 56'h0C_08_0F_03_89_0A_09, 56'h0C_08_0F_03_89_0A_0A}, // binary 12h PM
        '{1'b0, 1'b1, 56'h05_10_10_04_13_45_09, 56'h05_10_10_04_13_45_10}, // BCD digit carry
        '{1'b0, 1'b1, 56'h07_01_31_06_23_59_59, 56'h07_02_01_07_00_00_00}, // 31-day month
        '{1'b0, 1'b1, 56'h01_03_05_07_08_30_59, 56'h01_03_05_07_08_31_00}  // minute carry
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [2:0] osc_ctl_i = 3'b010;
    logic       bin_mode_i = 1'b0;
    logic       h24_mode_i = 1'b1;
    logic       hold_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_wday_i = '0;
    logic [7:0] ld_mday_i = '0, ld_mon_i = '0, ld_year_i = '0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
    logic       busy_o, done_o;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    cal_time_counter #(.UPD_DELAY(D), .BASE_CENTURY(20)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_ctl_i(osc_ctl_i),
        .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i), .hold_i(hold_i), .load_i(load_i),
        .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i), .ld_wday_i(ld_wday_i),
        .ld_mday_i(ld_mday_i), .ld_mon_i(ld_mon_i), .ld_year_i(ld_year_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o),
        .mon_o(mon_o), .year_o(year_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [55:0] vis();
        return {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_load(input logic [55:0] v);
        {ld_year_i, ld_mon_i, ld_mday_i, ld_wday_i, ld_hour_i, ld_min_i, ld_sec_i} = v;
    endtask

    task automatic do_load(input logic [55:0] v);
        @(negedge clk);
        load_i = 1'b1;
        put_load(v);
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    // watch n falling edges; any busy or done is a failure
    task automatic quiet(input int n, input string tag);
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (busy_o || done_o) seen = 1'b1;
        end
        chk(tag, {63'd0, seen}, 64'd0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset bytes", {8'd0, vis()}, {8'd0, 56'h00_01_01_01_00_00_00});
        chk("R11 reset flags", {62'd0, busy_o, done_o}, 64'd0);

        // R1..R6 and R8 from the vector table
        for (int i = 0; i < NV; i++) begin
            bin_mode_i = VECS[i].bin;
            h24_mode_i = VECS[i].h24;
            do_load(VECS[i].ld);
            chk("R10 load visible", {8'd0, vis()}, {8'd0, VECS[i].ld});
            tick_pulse();
            chk("R8 busy after tick", {63'd0, busy_o}, 64'd1);
            repeat (D - 1) @(negedge clk);
            chk("R8 not early", {7'd0, done_o, vis()}, {8'd0, VECS[i].ld});
            @(negedge clk);
            chk("R8 done and busy low", {62'd0, busy_o, done_o}, 64'd1);
            chk($sformatf("R1 R2 R3 R4 R5 R6 vector %0d", i), {8'd0, vis()}, {8'd0, VECS[i].exp});
            @(negedge clk);
            chk("R8 done one cycle", {63'd0, done_o}, 64'd0);
        end

        bin_mode_i = 1'b0;
        h24_mode_i = 1'b1;

        // R7: wrong divider field ignores ticks
        do_load(56'h10_05_20_03_08_15_30);
        osc_ctl_i = 3'b110;
        tick_pulse();
        quiet(D + 2, "R7 no update when stopped");
        chk("R7 bytes unchanged", {8'd0, vis()}, {8'd0, 56'h10_05_20_03_08_15_30});
        osc_ctl_i = 3'b010;

        // R9: hold freezes the visible bytes; release reloads from them
        do_load(56'h01_01_01_01_10_00_00);
        @(negedge clk);
        hold_i = 1'b1;
        tick_pulse();
        quiet(D + 1, "R9 no busy/done under hold");
        tick_pulse();
        quiet(D + 1, "R9 no busy/done under hold 2");
        chk("R9 frozen bytes", {8'd0, vis()}, {8'd0, 56'h01_01_01_01_10_00_00});
        do_load(56'h01_01_01_01_12_34_56);
        chk("R10 load under hold", {8'd0, vis()}, {8'd0, 56'h01_01_01_01_12_34_56});
        @(negedge clk);
        hold_i = 1'b0;
        @(negedge clk);
        tick_pulse();
        repeat (D) @(negedge clk);
        chk("R9 reload on release", {8'd0, vis()}, {8'd0, 56'h01_01_01_01_12_34_57});

        // R10: load wins over a tick in the same cycle
        @(negedge clk);
        load_i = 1'b1;
        tick_i = 1'b1;
        put_load(56'h02_02_02_02_02_02_05);
        @(negedge clk);
        load_i = 1'b0;
        tick_i = 1'b0;
        quiet(D + 1, "R10 tick dropped by load");
        chk("R10 load priority bytes", {8'd0, vis()}, {8'd0, 56'h02_02_02_02_02_02_05});

        // R10: load cancels an update in flight
        tick_pulse();
        do_load(56'h03_03_03_03_03_03_03);
        chk("R10 cancel clears busy", {63'd0, busy_o}, 64'd0);
        quiet(D + 1, "R10 cancelled update silent");
        chk("R10 cancel bytes", {8'd0, vis()}, {8'd0, 56'h03_03_03_03_03_03_03});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule